// File: doc/BRIEF.md
# Hot-Wire Resistance Error Calculator

This block sits between the sense-converter capture logic and the temperature-control loop of a constant-temperature hot-wire instrument. The wire is the lower leg of a two-resistor divider. A fixed 40 ohm resistor forms the upper leg, and the drive voltage is applied across the whole divider. On each start request the block takes the drive-voltage code and the measured wire-voltage code. It solves the divider relation RT = 40 * Vsense / (Vdrive - Vsense) for the wire resistance, and from it subtracts a target of 1.7 times the stored ambient resistance. The result is a signed error word that the loop controller consumes directly.

The ambient resistance is written through a small load port. The 1.7x target is scaled once at write time, using a gain of 435/256, so no multiply sits in the per-sample path. Division uses a restoring divider that produces a fixed number of quotient bits per clock. The latency is therefore constant and known. With the default of two bits per clock it is nine cycles, or 45 ns at 200 MHz.

Top module: `hw_err_calc`

## Requirements
- R1: After reset, res_o, err_o and sat_o are zero and busy_o and done_o are low.
- R2: When drive_code_i > sense_code_i, res_o equals floor(10240 * sense / (drive - sense)). This is the wire resistance in ohms as an unsigned value with 8 integer and 8 fraction bits (bit 8 weighs 1 ohm).
- R3: When drive_code_i <= sense_code_i, sat_o is 1 and res_o is 16'hFFFF.
- R4: When the exact quotient of R2 is 65536 or more, sat_o is 1 and res_o is 16'hFFFF. A quotient of 65535 or less gives sat_o = 0.
- R5: A cycle with amb_we_i high loads the target floor(amb_res_i * 435 / 256), where amb_res_i uses the same 8.8 ohm format. Every result that completes afterwards uses this target.
- R6: err_o is the 17-bit two's-complement value res_o minus the target.
- R7: When res_o minus the target is below -65536, err_o is -65536. It never exceeds 65535.
- R8: done_o rises exactly 16/STEP_BITS + 1 clock edges after the edge that accepts start_i, for any operands.
- R9: done_o is high for one cycle per result. busy_o is high from the edge that accepts start until the edge that raises done_o.
- R10: start_i is ignored while busy_o is high. No extra result is produced, and the running result keeps the operands captured at acceptance.
- R11: res_o, err_o and sat_o change only on the edge that raises done_o and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a calculation; accepted only while idle |
| drive_code_i | input | 16 | Unsigned code of the voltage applied to the divider |
| sense_code_i | input | 16 | Unsigned code of the voltage measured across the wire |
| amb_we_i | input | 1 | Load the ambient resistance and rescale the target |
| amb_res_i | input | 16 | Ambient wire resistance, unsigned 8.8 ohms |
| busy_o | output | 1 | A calculation is in progress |
| done_o | output | 1 | One-cycle pulse: new outputs are valid |
| sat_o | output | 1 | Resistance was clamped (divider inverted or quotient too large) |
| res_o | output | 16 | Wire resistance, unsigned 8.8 ohms |
| err_o | output | 17 | Resistance minus target, two's complement, saturating |

## Verification
The assertions assume that start_i is a synchronous level that the block samples only while busy_o is low. They also assume that amb_res_i is meaningful only in cycles where amb_we_i is high. Operands may change freely while a calculation runs. The stimulus drives all inputs half a clock away from the sampling edge. It writes the ambient value only while the block is idle, so the target that a result uses is always unambiguous. It also deliberately raises start_i in the middle of a calculation with different operands, to show that such a request is dropped.

// File: rtl/hwe_pkg.sv
package hwe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_FIN  = 2'd2
    } hwe_state_e;

    // 1.7 in unsigned 2.8 fixed point, rounded to nearest (435/256)
    localparam int HWE_GAIN_Q8 = 435;

endpackage

// File: rtl/hwe_div_stage.sv
// One restoring-division step: shift one numerator bit into the partial
// remainder and subtract the divisor when it fits.
module hwe_div_stage #(
    parameter int DEN_W = 16
) (
    input  logic [DEN_W-1:0] rem_i,
    input  logic             bit_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [DEN_W-1:0] rem_o,
    output logic             q_o
);
    logic [DEN_W:0] sh;

    always_comb begin
        sh    = {rem_i, bit_i};
        q_o   = (sh >= {1'b0, den_i});
        rem_o = q_o ? DEN_W'(sh - {1'b0, den_i}) : sh[DEN_W-1:0];
    end
endmodule

// File: rtl/hwe_div_core.sv
// STEP chained restoring steps evaluated in one clock; bits_i is MSB first.
module hwe_div_core #(
    parameter int DEN_W = 16,
    parameter int STEP  = 2
) (
    input  logic [DEN_W-1:0] rem_i,
    input  logic [STEP-1:0]  bits_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [DEN_W-1:0] rem_o,
    output logic [STEP-1:0]  q_o
);
    logic [STEP:0][DEN_W-1:0] chain;

    assign chain[0] = rem_i;

    for (genvar g = 0; g < STEP; g++) begin : g_stage
        hwe_div_stage #(.DEN_W(DEN_W)) stage_i (
            .rem_i (chain[g]),
            .bit_i (bits_i[STEP-1-g]),
            .den_i (den_i),
            .rem_o (chain[g+1]),
            .q_o   (q_o[STEP-1-g])
        );
    end

    assign rem_o = chain[STEP];
endmodule

// File: rtl/hwe_target_scale.sv
// Scales the ambient resistance by the Q.GAIN_FRAC gain, truncating.
module hwe_target_scale #(
    parameter int CODE_W    = 16,
    parameter int GAIN_Q    = 435,
    parameter int GAIN_FRAC = 8,
    parameter int TGT_W     = 17
) (
    input  logic [CODE_W-1:0] amb_i,
    output logic [TGT_W-1:0]  tgt_o
);
    localparam int PROD_W = TGT_W + GAIN_FRAC;

    always_comb begin
        tgt_o = TGT_W'((PROD_W'(amb_i) * PROD_W'(GAIN_Q)) >> GAIN_FRAC);
    end
endmodule

// File: rtl/hwe_err_sat.sv
// Signed difference resistance - target, clamped to the ERR_W range.
module hwe_err_sat #(
    parameter int RES_W = 16,
    parameter int TGT_W = 17,
    parameter int ERR_W = 17
) (
    input  logic [RES_W-1:0] res_i,
    input  logic [TGT_W-1:0] tgt_i,
    output logic [ERR_W-1:0] err_o
);
    localparam int D_W = ((RES_W > TGT_W) ? RES_W : TGT_W) + 2;
    localparam logic signed [D_W-1:0] MAXV = D_W'((1 << (ERR_W-1)) - 1);
    localparam logic signed [D_W-1:0] MINV = D_W'(-(1 << (ERR_W-1)));

    logic signed [D_W-1:0] diff;

    always_comb begin
        diff = $signed(D_W'(res_i)) - $signed(D_W'(tgt_i));
        if (diff > MAXV)
            err_o = ERR_W'(MAXV);
        else if (diff < MINV)
            err_o = ERR_W'(MINV);
        else
            err_o = diff[ERR_W-1:0];
    end
endmodule

// File: rtl/hw_err_calc.sv
module hw_err_calc
    import hwe_pkg::*;
#(
    parameter int CODE_W    = 16,
    parameter int FRAC_W    = 8,
    parameter int TOP_OHMS  = 40,
    parameter int GAIN_Q    = HWE_GAIN_Q8,
    parameter int GAIN_FRAC = 8,
    parameter int STEP_BITS = 2,
    parameter int ERR_W     = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] drive_code_i,
    input  logic [CODE_W-1:0] sense_code_i,
    input  logic              amb_we_i,
    input  logic [CODE_W-1:0] amb_res_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sat_o,
    output logic [CODE_W-1:0] res_o,
    output logic [ERR_W-1:0]  err_o
);
    localparam int RES_W   = CODE_W;
    localparam int SCALE   = TOP_OHMS << FRAC_W;
    localparam int SCALE_W = $clog2(SCALE + 1);
    localparam int NUM_W   = CODE_W + SCALE_W;
    localparam int HI_W    = NUM_W - RES_W;
    localparam int ITERS   = RES_W / STEP_BITS;
    localparam int CNT_W   = $clog2(ITERS + 1);
    localparam int TGT_W   = CODE_W + $clog2(GAIN_Q + 1) - GAIN_FRAC;

    typedef struct packed {
        hwe_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] den;
        logic [CODE_W-1:0] rem;
        logic [RES_W-1:0]  nbits;
        logic [RES_W-1:0]  quo;
        logic              clamp;
        logic [RES_W-1:0]  res;
        logic [ERR_W-1:0]  err;
        logic              sat;
        logic              done;
        logic [TGT_W-1:0]  tgt;
    } regs_t;

    regs_t regs_q, regs_d;

    // operand preparation at acceptance
    logic [CODE_W-1:0]    den_w;
    logic [NUM_W-1:0]     num_w;
    logic [HI_W-1:0]      hi_w;
    logic                 clamp_w;

    always_comb begin
        den_w   = drive_code_i - sense_code_i;
        num_w   = NUM_W'(sense_code_i) * NUM_W'(SCALE);
        hi_w    = num_w[NUM_W-1:RES_W];
        clamp_w = (drive_code_i <= sense_code_i) || (CODE_W'(hi_w) >= den_w);
    end

    // datapath helpers
    logic [CODE_W-1:0]    div_rem;
    logic [STEP_BITS-1:0] div_q;
    logic [TGT_W-1:0]     tgt_w;
    logic [RES_W-1:0]     res_fin;
    logic [ERR_W-1:0]     err_w;

    hwe_div_core #(.DEN_W(CODE_W), .STEP(STEP_BITS)) div_i (
        .rem_i  (regs_q.rem),
        .bits_i (regs_q.nbits[RES_W-1 -: STEP_BITS]),
        .den_i  (regs_q.den),
        .rem_o  (div_rem),
        .q_o    (div_q)
    );

    hwe_target_scale #(
        .CODE_W(CODE_W), .GAIN_Q(GAIN_Q), .GAIN_FRAC(GAIN_FRAC), .TGT_W(TGT_W)
    ) tgt_i (
        .amb_i (amb_res_i),
        .tgt_o (tgt_w)
    );

    assign res_fin = regs_q.clamp ? '1 : regs_q.quo;

    hwe_err_sat #(.RES_W(RES_W), .TGT_W(TGT_W), .ERR_W(ERR_W)) err_i (
        .res_i (res_fin),
        .tgt_i (regs_q.tgt),
        .err_o (err_w)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        if (amb_we_i)
            regs_d.tgt = tgt_w;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.st    = ST_DIV;
                    regs_d.cnt   = CNT_W'(ITERS);
                    regs_d.den   = den_w;
                    regs_d.rem   = CODE_W'(hi_w);
                    regs_d.nbits = num_w[RES_W-1:0];
                    regs_d.quo   = '0;
                    regs_d.clamp = clamp_w;
                end
            end
            ST_DIV: begin
                regs_d.rem   = div_rem;
                regs_d.nbits = regs_q.nbits << STEP_BITS;
                regs_d.quo   = (regs_q.quo << STEP_BITS) | RES_W'(div_q);
                regs_d.cnt   = regs_q.cnt - CNT_W'(1);
                if (regs_q.cnt == CNT_W'(1))
                    regs_d.st = ST_FIN;
            end
            ST_FIN: begin
                regs_d.res  = res_fin;
                regs_d.err  = err_w;
                regs_d.sat  = regs_q.clamp;
                regs_d.done = 1'b1;
                regs_d.st   = ST_IDLE;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    assign busy_o = (regs_q.st != ST_IDLE);
    assign done_o = regs_q.done;
    assign sat_o  = regs_q.sat;
    assign res_o  = regs_q.res;
    assign err_o  = regs_q.err;

endmodule

// File: rtl/hwe_chk.sv
module hwe_chk #(
    parameter int RES_W = 16,
    parameter int STEP  = 2,
    parameter int ERR_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             sat,
    input logic [RES_W-1:0] res,
    input logic [ERR_W-1:0] err
);
    localparam int ITERS = RES_W / STEP;
    localparam int LEN_W = $clog2(ITERS + 3);

    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            len_q <= '0;
        else if (busy)
            len_q <= len_q + LEN_W'(1);
        else
            len_q <= '0;
    end

    // R9: an idle request makes the block busy on the next cycle
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy ends exactly when done appears
    a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: busy lasts the fixed iteration count plus the finishing cycle
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (len_q == LEN_W'(ITERS + 1)));

    // R11: outputs only move together with done
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res) && $stable(err) && $stable(sat)));

    // R3: a clamped result is the full-scale code
    a_r3_sat_max: assert property (@(posedge clk) disable iff (!rst_n)
        sat |-> (&res));

    // R6: the error never exceeds the resistance (target is non-negative)
    a_r6_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($signed(err) <= $signed({1'b0, res})));

endmodule

bind hw_err_calc hwe_chk #(
    .RES_W (CODE_W),
    .STEP  (STEP_BITS),
    .ERR_W (ERR_W)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .busy  (busy_o),
    .done  (done_o),
    .sat   (sat_o),
    .res   (res_o),
    .err   (err_o)
);

// File: tb/hw_err_calc_tb.sv
`timescale 1ns/1ps
module hw_err_calc_tb_top;
    localparam int STEP  = 2;
    localparam int ITERS = 16 / STEP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] drive = '0;
    logic [15:0] sense = '0;
    logic        amb_we = 1'b0;
    logic [15:0] amb = '0;
    logic        busy, done, sat;
    logic [15:0] res;
    logic [16:0] err;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    hw_err_calc #(.STEP_BITS(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .drive_code_i(drive), .sense_code_i(sense),
        .amb_we_i(amb_we), .amb_res_i(amb),
        .busy_o(busy), .done_o(done), .sat_o(sat),
        .res_o(res), .err_o(err)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int     m_cnt, m_v1, m_v2, m_tgt, m_res, m_err;
    bit     m_sat, m_done;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_tgt = 0; m_res = 0; m_err = 0; m_sat = 0; m_done = 0;
        end else begin
            int new_tgt;
            new_tgt = m_tgt;
            if (amb_we) new_tgt = (int'(amb) * 435) / 256;
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    longint q;
                    if (m_v1 <= m_v2) begin
                        m_sat = 1; m_res = 65535;
                    end else begin
                        q = (longint'(m_v2) * 10240) / longint'(m_v1 - m_v2);
                        if (q > 65535) begin m_sat = 1; m_res = 65535; end
                        else begin m_sat = 0; m_res = int'(q); end
                    end
                    m_err = m_res - m_tgt;
                    if (m_err < -65536) m_err = -65536;
                    if (m_err > 65535)  m_err = 65535;
                    m_done = 1;
                end
            end else if (start) begin
                m_v1 = int'(drive); m_v2 = int'(sense); m_cnt = ITERS + 1;
            end
            m_tgt = new_tgt;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (m_cnt > 0), "R9 busy vs model", busy, m_cnt > 0);
            check(done == m_done, "R9 done vs model", done, m_done);
            check(int'(res) == m_res, "R2 res vs model", res, m_res);
            check(int'($signed(err)) == m_err, "R6 err vs model", $signed(err), m_err);
            check(sat == m_sat, "R3 sat vs model", sat, m_sat);
        end
    end

    // ---------------- stimulus ----------------
    task automatic write_ra(input logic [15:0] v);
        @(negedge clk); amb_we = 1'b1; amb = v;
        @(negedge clk); amb_we = 1'b0;
    endtask

    task automatic calc(input int v1, input int v2, input int e_res, input bit e_sat,
                        input int e_err, input string tag);
        int cyc;
        @(negedge clk); drive = 16'(v1); sense = 16'(v2); start = 1'b1;
        @(negedge clk); start = 1'b0; cyc = 0;
        while (!done) begin @(negedge clk); cyc++; end
        check(cyc == ITERS + 1, "R8 latency", cyc, ITERS + 1);
        check(int'(res) == e_res, {tag, " res"}, res, e_res);
        check(sat == e_sat, {tag, " sat"}, sat, e_sat);
        check(int'($signed(err)) == e_err, {tag, " R6 err"}, $signed(err), e_err);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(res == 0 && err == 0 && !sat, "R1 outputs", res, 0);
        check(!busy && !done, "R1 flags", busy, 0);

        write_ra(16'h1000);                 // 16 ohm -> target 6960
        calc(1000, 500, 10240, 0, 3280, "R2 forty ohm");
        calc(40000, 16000, 6826, 0, -134, "R2 truncation");
        calc(5, 0, 0, 0, -6960, "R2 zero sense");
        calc(7, 6, 61440, 0, 54480, "R4 below limit");
        calc(37, 32, 65535, 1, 58575, "R4 exact limit");
        calc(1000, 999, 65535, 1, 58575, "R4 large quotient");
        calc(1234, 1234, 65535, 1, 58575, "R3 equal codes");
        calc(100, 200, 65535, 1, 58575, "R3 inverted codes");

        write_ra(16'h2800);                 // 40 ohm -> target 17400
        calc(1000, 500, 10240, 0, -7160, "R5 new target");

        write_ra(16'hFFFF);                 // target 111358
        calc(60000, 1, 0, 0, -65536, "R7 floor zero res");
        calc(1000, 500, 10240, 0, -65536, "R7 floor");

        write_ra(16'h0000);
        calc(37, 32, 65535, 1, 65535, "R6 top of range");

        // R10: request during busy is dropped
        begin
            int extra;
            @(negedge clk); drive = 16'd1000; sense = 16'd500; start = 1'b1;
            @(negedge clk); start = 1'b0;
            @(negedge clk); drive = 16'd40000; sense = 16'd16000; start = 1'b1;
            @(negedge clk); start = 1'b0; drive = 16'd3; sense = 16'd9;
            while (!done) @(negedge clk);
            check(res == 16'd10240, "R10 captured operands", res, 10240);
            extra = 0;
            for (int i = 0; i < ITERS + 4; i++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R10 no extra result", extra, 0);
        end

        // R11: outputs hold while inputs wander without a start
        begin
            logic [15:0] r0;
            r0 = res;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk); drive = 16'(i * 777); sense = 16'(i * 31);
            end
            check(res == r0 && !sat, "R11 hold", res, r0);
        end

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule